// File: doc/BRIEF.md
# JTAG TAP Master Scan Engine

This block drives an external test access port (TAP) chain from inside a chip. It generates TCK, TMS and TDI from the system clock and samples TDO. A caller selects one of three operations and pulses a start strobe: a TAP reset, an instruction-register scan or a data-register scan. Every operation starts and ends in Run-Test/Idle.

For a scan, the caller supplies a bit count of 1 to `MAX_BITS` and a shift-in vector. The engine walks the TAP controller into the shift state and moves the bits least significant first. It leaves the shift state on the last bit, then goes through Update back to Idle. The bits seen on TDO are collected into a capture vector. A one-cycle done pulse marks the end of the operation.

Each TCK half-period lasts a programmable number of system clocks, so the same block serves fast on-chip chains and slow board-level chains. The block does not build register-access frames and does not handle the TRST pin.

Top module: `jtag_scan_master`

## Requirements
- R1: After reset, tck_o=1, tms_o=1, tdi_o=0, busy_o=0, done_o=0 and dout_o is all zeros. Whenever busy_o=0 the pins hold tck_o=1, tms_o=1, tdi_o=0.
- R2: A command is accepted on the clock edge where start_i=1 and busy_o=0. From that edge busy_o=1 and each TCK period is half_i+1 system clocks with tck_o=0, followed by half_i+1 system clocks with tck_o=1. tms_o and tdi_o change only when tck_o falls.
- R3: op_i=0 (reset) produces 10 TCK periods with tms_o=1 and then 10 with tms_o=0, with tdi_o=0 throughout.
- R4: op_i=1 (instruction scan) starts with four TCK periods where tms_o is 1,1,0,0 and tdi_o=0.
- R5: op_i=2 (data scan) starts with three TCK periods where tms_o is 1,0,0 and tdi_o=0.
- R6: In the shift periods, period i drives tdi_o=din_i[i] for i = 0 .. nbits_i-1. tms_o is 0 in these periods except in the final one, where it is 1.
- R7: After the final shift period there are two more periods, with tms_o=1 and then tms_o=0, both with tdi_o=0.
- R8: The TDO value present at the end of the low half of shift period i is stored in dout_o[i]. dout_o bits at or above nbits_i, and all bits after a reset operation, keep their previous value. dout_o changes only in the cycle in which tck_o rises.
- R9: On the edge that ends the high half of the last period, busy_o falls and done_o is 1 for exactly one cycle. The pins return to their idle values on that same edge.
- R10: start_i is ignored while busy_o=1. The running sequence is unaffected and no further operation follows it.
- R11: Some commands are ignored and leave busy_o=0 and dout_o unchanged: a scan with nbits_i=0, a scan with nbits_i greater than MAX_BITS, and op_i=3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command strobe |
| op_i | input | 2 | Operation: 0 reset, 1 instruction scan, 2 data scan, 3 none |
| nbits_i | input | $clog2(MAX_BITS+1) | Number of bits to shift |
| din_i | input | MAX_BITS | Shift-in vector, bit 0 first |
| half_i | input | DIV_W | TCK half-period minus one, in system clocks |
| tdo_i | input | 1 | Serial data from the chain |
| tck_o | output | 1 | Test clock |
| tms_o | output | 1 | Test mode select |
| tdi_o | output | 1 | Serial data to the chain |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| dout_o | output | MAX_BITS | Captured TDO vector |

## Verification
The bench builds the engine with its default parameters: MAX_BITS=128 and DIV_W=8. The 128-bit default makes a full-width data scan and a single-bit scan both reachable. In the single-bit scan the first shifted bit is also the exit bit. Half-period settings of 0, 1 and 2 show that each TCK half stretches by exactly one clock per step. A short instruction scan run after a full-width capture shows that the capture bits above the count are kept. Counts of 0 and 129, and the unused op code, reach the command filter.

// File: rtl/jsm_pkg.sv
package jsm_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_IR    = 2'd1,
        OP_DR    = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_RHI   = 3'd1,
        PH_RLO   = 3'd2,
        PH_PRE   = 3'd3,
        PH_SHIFT = 3'd4,
        PH_POST  = 3'd5
    } phase_e;

    localparam int RESET_CLOCKS = 10;

endpackage

// File: rtl/jsm_half_timer.sv
module jsm_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             zero_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = half_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/jsm_walk.sv
module jsm_walk
    import jsm_pkg::*;
#(
    parameter int MAX_BITS = 128,
    parameter int IDX_W    = 8
) (
    input  phase_e              phase_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic                ir_i,
    input  logic [IDX_W-1:0]    nbits_i,
    input  logic [MAX_BITS-1:0] din_i,
    output logic                tms_o,
    output logic                tdi_o
);
    localparam int SEL_W = $clog2(MAX_BITS);

    always_comb begin
        tms_o = 1'b0;
        tdi_o = 1'b0;
        case (phase_i)
            PH_RHI:   tms_o = 1'b1;
            PH_RLO:   tms_o = 1'b0;
            PH_PRE:   tms_o = ir_i ? (idx_i < IDX_W'(2)) : (idx_i == '0);
            PH_SHIFT: begin
                tdi_o = din_i[idx_i[SEL_W-1:0]];
                tms_o = (idx_i == nbits_i - IDX_W'(1));
            end
            PH_POST:  tms_o = (idx_i == '0);
            default:  tms_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/jtag_scan_master.sv
module jtag_scan_master
    import jsm_pkg::*;
#(
    parameter int MAX_BITS = 128,
    parameter int DIV_W    = 8,
    localparam int CNT_W   = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [1:0]          op_i,
    input  logic [CNT_W-1:0]    nbits_i,
    input  logic [MAX_BITS-1:0] din_i,
    input  logic [DIV_W-1:0]    half_i,
    input  logic                tdo_i,
    output logic                tck_o,
    output logic                tms_o,
    output logic                tdi_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [MAX_BITS-1:0] dout_o
);
    localparam int IDX_W = (CNT_W > 4) ? CNT_W : 4;
    localparam int SEL_W = $clog2(MAX_BITS);

    typedef struct packed {
        logic                busy;
        logic                done;
        logic                tck;
        logic                tms;
        logic                tdi;
        logic                ir;
        phase_e              phase;
        logic [IDX_W-1:0]    idx;
        logic [IDX_W-1:0]    nbits;
        logic [MAX_BITS-1:0] din;
        logic [MAX_BITS-1:0] cap;
    } state_t;

    state_t           s_d, s_q;
    logic             go, cur_last, tmr_load, tmr_zero;
    logic             nx_ir, nx_tms, nx_tdi;
    phase_e           nx_ph;
    logic [IDX_W-1:0] nx_idx;

    // command filter
    always_comb begin
        go = 1'b0;
        if (start_i && !s_q.busy) begin
            if (op_e'(op_i) == OP_RESET)
                go = 1'b1;
            else if (op_e'(op_i) == OP_IR || op_e'(op_i) == OP_DR)
                go = (nbits_i != '0) && (nbits_i <= CNT_W'(MAX_BITS));
        end
    end

    // end of the current phase
    always_comb begin
        case (s_q.phase)
            PH_RHI, PH_RLO: cur_last = (s_q.idx == IDX_W'(RESET_CLOCKS - 1));
            PH_PRE:         cur_last = (s_q.idx == (s_q.ir ? IDX_W'(3) : IDX_W'(2)));
            PH_SHIFT:       cur_last = (s_q.idx == s_q.nbits - IDX_W'(1));
            PH_POST:        cur_last = (s_q.idx == IDX_W'(1));
            default:        cur_last = 1'b1;
        endcase
    end

    // position of the next TCK period
    always_comb begin
        nx_ir  = s_q.ir;
        nx_idx = '0;
        nx_ph  = s_q.phase;
        if (!s_q.busy) begin
            nx_ir = (op_e'(op_i) == OP_IR);
            nx_ph = (op_e'(op_i) == OP_RESET) ? PH_RHI : PH_PRE;
        end else if (cur_last) begin
            case (s_q.phase)
                PH_RHI:   nx_ph = PH_RLO;
                PH_PRE:   nx_ph = PH_SHIFT;
                PH_SHIFT: nx_ph = PH_POST;
                default:  nx_ph = PH_IDLE;
            endcase
        end else begin
            nx_idx = s_q.idx + IDX_W'(1);
        end
    end

    jsm_walk #(.MAX_BITS(MAX_BITS), .IDX_W(IDX_W)) u_walk (
        .phase_i (nx_ph),
        .idx_i   (nx_idx),
        .ir_i    (nx_ir),
        .nbits_i (s_q.nbits),
        .din_i   (s_q.din),
        .tms_o   (nx_tms),
        .tdi_o   (nx_tdi)
    );

    jsm_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .half_i (half_i),
        .zero_o (tmr_zero)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        tmr_load = 1'b0;
        if (go) begin
            tmr_load  = 1'b1;
            s_d.busy  = 1'b1;
            s_d.ir    = nx_ir;
            s_d.nbits = IDX_W'(nbits_i);
            s_d.din   = din_i;
            s_d.phase = nx_ph;
            s_d.idx   = nx_idx;
            s_d.tck   = 1'b0;
            s_d.tms   = nx_tms;
            s_d.tdi   = nx_tdi;
        end else if (s_q.busy && tmr_zero) begin
            tmr_load = 1'b1;
            if (!s_q.tck) begin
                s_d.tck = 1'b1;
                if (s_q.phase == PH_SHIFT)
                    s_d.cap[s_q.idx[SEL_W-1:0]] = tdo_i;
            end else if (nx_ph == PH_IDLE) begin
                s_d.busy  = 1'b0;
                s_d.done  = 1'b1;
                s_d.phase = PH_IDLE;
                s_d.idx   = '0;
                s_d.tms   = 1'b1;
                s_d.tdi   = 1'b0;
            end else begin
                s_d.phase = nx_ph;
                s_d.idx   = nx_idx;
                s_d.tck   = 1'b0;
                s_d.tms   = nx_tms;
                s_d.tdi   = nx_tdi;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
            s_q.tck   <= 1'b1;
            s_q.tms   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tck_o  = s_q.tck;
    assign tms_o  = s_q.tms;
    assign tdi_o  = s_q.tdi;
    assign busy_o = s_q.busy;
    assign done_o = s_q.done;
    assign dout_o = s_q.cap;
endmodule

// File: rtl/jsm_checker.sv
module jsm_checker #(
    parameter int MAX_BITS = 128
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tck_o,
    input logic                tms_o,
    input logic                tdi_o,
    input logic                busy_o,
    input logic                done_o,
    input logic [MAX_BITS-1:0] dout_o
);
    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (tck_o && tms_o && !tdi_o)); // R1

    AST_START_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !tck_o); // R2

    AST_PINS_MOVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$fell(tck_o)) |-> ($stable(tms_o) && $stable(tdi_o))); // R2

    AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(tck_o) |-> $stable(dout_o)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R9
endmodule

bind jtag_scan_master jsm_checker #(.MAX_BITS(MAX_BITS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tck_o  (tck_o),
    .tms_o  (tms_o),
    .tdi_o  (tdi_o),
    .busy_o (busy_o),
    .done_o (done_o),
    .dout_o (dout_o)
);

// File: tb/sim_jtag_scan_master.sv
module sim_jtag_scan_master;
    localparam int MAX_BITS = 128;
    localparam int DIV_W    = 8;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start_i = 1'b0;
    logic [1:0]          op_i = 2'd0;
    logic [CNT_W-1:0]    nbits_i = '0;
    logic [MAX_BITS-1:0] din_i = '0;
    logic [DIV_W-1:0]    half_i = '0;
    logic                tdo_i;
    logic                tck_o, tms_o, tdi_o, busy_o, done_o;
    logic [MAX_BITS-1:0] dout_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [255:0]        src = '0;
    int                  fall_cnt = 0;
    int                  base = 0;
    logic                prev_tck = 1'b1;
    logic [MAX_BITS-1:0] exp_dout = '0;

    always #10 clk = ~clk;

    jtag_scan_master #(.MAX_BITS(MAX_BITS), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .nbits_i(nbits_i), .din_i(din_i), .half_i(half_i), .tdo_i(tdo_i),
        .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o), .busy_o(busy_o),
        .done_o(done_o), .dout_o(dout_o)
    );

    // bench-side chain: TDO presents src[k] during TCK period k
    always @(negedge clk) begin
        if (prev_tck && !tck_o) fall_cnt <= fall_cnt + 1;
        prev_tck <= tck_o;
    end
    assign tdo_i = src[8'(fall_cnt - base - 1)];

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input int n,
                          input logic [MAX_BITS-1:0] din, input int half,
                          input bit poke);
        bit tq[$];
        bit dq[$];
        string tagq[$];
        int pre;
        int h;
        pre = 0;
        h = half + 1;
        if (op == 2'd0) begin
            for (int i = 0; i < 10; i++) begin tq.push_back(1); dq.push_back(0); tagq.push_back("R3"); end
            for (int i = 0; i < 10; i++) begin tq.push_back(0); dq.push_back(0); tagq.push_back("R3"); end
        end else begin
            if (op == 2'd1) begin
                pre = 4;
                tq.push_back(1); tq.push_back(1); tq.push_back(0); tq.push_back(0);
                for (int i = 0; i < 4; i++) begin dq.push_back(0); tagq.push_back("R4"); end
            end else begin
                pre = 3;
                tq.push_back(1); tq.push_back(0); tq.push_back(0);
                for (int i = 0; i < 3; i++) begin dq.push_back(0); tagq.push_back("R5"); end
            end
            for (int i = 0; i < n; i++) begin
                tq.push_back(i == n - 1); dq.push_back(din[i]); tagq.push_back("R6");
            end
            tq.push_back(1); dq.push_back(0); tagq.push_back("R7");
            tq.push_back(0); dq.push_back(0); tagq.push_back("R7");
        end
        src = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        base = fall_cnt;
        @(negedge clk);
        op_i = op; nbits_i = CNT_W'(n); din_i = din; half_i = DIV_W'(half);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int s = 0; s < tq.size(); s++) begin
            for (int ph = 0; ph < 2; ph++) begin
                for (int c = 0; c < h; c++) begin
                    if (poke && s == 1 && ph == 0 && c == 0) begin
                        start_i = 1'b1; op_i = 2'd2; nbits_i = CNT_W'(5);
                    end
                    if (poke && s == 2 && ph == 0 && c == 0) start_i = 1'b0;
                    chk({busy_o, done_o, tck_o} == {1'b1, 1'b0, ph[0]}, "R2",
                        128'({busy_o, done_o, tck_o}), 128'({1'b1, 1'b0, ph[0]}));
                    chk({tms_o, tdi_o} == {tq[s], dq[s]}, tagq[s],
                        128'({tms_o, tdi_o}), 128'({tq[s], dq[s]}));
                    @(negedge clk);
                end
            end
        end
        for (int i = 0; i < n && op != 2'd0; i++) exp_dout[i] = src[pre + i];
        chk({busy_o, done_o, tck_o, tms_o, tdi_o} == 5'b01110, "R9",
            128'({busy_o, done_o, tck_o, tms_o, tdi_o}), 128'(5'b01110));
        chk(dout_o == exp_dout, "R8", dout_o, exp_dout);
        @(negedge clk);
        chk(done_o == 1'b0, "R9", 128'(done_o), 128'(0));
        if (poke) begin
            for (int i = 0; i < 6; i++) begin
                chk(busy_o == 1'b0, "R10", 128'(busy_o), 128'(0));
                @(negedge clk);
            end
        end
    endtask

    task automatic try_ignored(input logic [1:0] op, input int n);
        @(negedge clk);
        op_i = op; nbits_i = CNT_W'(n); din_i = '1; half_i = '0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk({busy_o, tck_o, tms_o} == 3'b011, "R11",
                128'({busy_o, tck_o, tms_o}), 128'(3'b011));
            chk(dout_o == exp_dout, "R11", dout_o, exp_dout);
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({tck_o, tms_o, tdi_o, busy_o, done_o} == 5'b11000, "R1",
            128'({tck_o, tms_o, tdi_o, busy_o, done_o}), 128'(5'b11000));
        chk(dout_o == '0, "R1", dout_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({tck_o, tms_o, tdi_o, busy_o} == 4'b1100, "R1",
            128'({tck_o, tms_o, tdi_o, busy_o}), 128'(4'b1100));

        run_op(2'd0, 0, '0, 0, 0);                                        // R3
        run_op(2'd1, 5, 128'h15, 1, 0);                                   // R4 R6 R7
        run_op(2'd2, 128, {$urandom, $urandom, $urandom, $urandom}, 0, 0); // R5 R6 R8
        run_op(2'd2, 1, 128'h1, 2, 0);                                    // R6 single bit
        run_op(2'd1, 37, {4{32'h5A3C_0F96}}, 0, 0);                       // R8 upper bits kept
        run_op(2'd0, 0, '0, 1, 0);                                        // R8 reset keeps capture
        run_op(2'd2, 9, 128'h1A5, 0, 1);                                  // R10
        try_ignored(2'd2, 0);                                             // R11
        try_ignored(2'd1, 129);                                           // R11
        try_ignored(2'd3, 8);                                             // R11
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule